// File: doc/BRIEF.md
# Gated Pulse-Width Capture Timer

This block measures how long an external input stays at its active level, one measurement after another. A 16-bit counter runs from the system clock through a power-of-two prescaler. A gate stops the counter whenever the synchronized input sits at a programmable inactive level. On a selected input edge the running count is copied into a capture register, and the counter can be loaded from a reload register in the same cycle. With a reload value of zero, a gate polarity that counts while the input is high and capture on the falling edge, each captured value is the width of the preceding high pulse in prescaled clocks.

Software programs the block through a small write/read port. It can run the unit continuously, so that every capture edge yields a result. It can also frame a single measurement. An armed single-shot cycle begins at the first capture edge, or, if the gate is closed while armed, at the moment the gate opens. It ends at the next capture edge. After the cycle ends the counter keeps counting, but further edges are ignored until software arms again. A sticky capture flag, gated by an enable bit, drives the interrupt output.

Top module: `gated_pulse_timer`

## Requirements
- R1: After reset the control, reload, count, capture and status registers all read 0000h and `irq` is 0.
- R2: With the gate enabled and gate polarity 0, the counter advances once per prescaler tick only while the synchronized input is high. With divide code 0 and reload 0000h, a falling-edge capture equals the number of clock cycles the input was high.
- R3: With gate polarity 1 the counter advances only while the synchronized input is low, so a rising-edge capture equals the low-pulse width.
- R4: Control bits [8:7] select the capture edge: 00 none, 01 rising, 10 falling, 11 both. With code 00 input edges change neither the capture register nor the capture flag.
- R5: Control bit 5 set: a capture loads the counter from the reload register in the same cycle. Bit 5 clear: the counter keeps accumulating across captures.
- R6: Control bits [11:9] hold a code k that divides the clock by 2^k. After the control write that starts the unit, the count is n exactly 2^k·n cycles later when the gate is disabled (bit 3 clear).
- R7: Single-shot mode (bit 2 set, run field [1:0] = 01) armed while the gate is closed moves to the wait state. The cycle begins when the gate opens, without reloading the counter. It ends at the next capture edge with a capture and the capture flag set.
- R8: Single-shot mode armed while the gate is open does not count. The first capture edge starts the cycle (capture and reload, no flag). The next capture edge ends it and sets the flag.
- R9: After a single-shot cycle ends, the state is done. Further edges leave the capture register and flag unchanged, while the counter keeps counting whenever the gate is open. Writing run code 01 again re-arms the unit.
- R10: The capture flag (status bit 0) stays set until a write of 1 to that bit. `irq` equals the flag ANDed with control bit 6.
- R11: An increment from FFFFh loads the reload value and sets the overflow flag (status bit 1), which is cleared by writing 1 to it.
- R12: With single-shot off (bit 2 clear) and a non-zero run field, every selected edge captures and sets the capture flag.
- R13: Addresses are 0 control, 1 reload, 2 count, 3 capture (read-only), 4 status. Status bits [4:2] give the state: 0 idle, 1 armed, 2 wait-gate, 3 active, 4 done. Writing run field 00 returns to idle and holds the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous measured input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Capture interrupt request |

## Verification
A wrong sequencer state shows within a few cycles in the status state field. It also shows one capture later as a missing or extra flag, or as a capture register that changes in the done state. A counter that is gated or prescaled wrongly shows as a capture that is off by one or more. That error is seen at the first pulse after the fault, about three cycles after the input's trailing edge. A faulty reload path shows as an accumulated value in the second capture of a pulse pair.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    localparam logic [1:0] RUN_STOP  = 2'b00;
    localparam logic [1:0] RUN_SHOT  = 2'b01;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_ARMED  = 3'd1,
        SQ_WAITG  = 3'd2,
        SQ_ACTIVE = 3'd3,
        SQ_DONE   = 3'd4
    } sq_state_e;

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/pwt_prescaler.sv
module pwt_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int PRE_W = 1 << DIV_W;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] one_w, mask_w;

    always_comb begin
        one_w  = PRE_W'(1);
        mask_w = (one_w << div_code) - one_w;
        tick   = en && (pre_q == mask_w);
        if (!en)       pre_d = '0;
        else if (tick) pre_d = '0;
        else           pre_d = pre_q + one_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/pwt_shot_seq.sv
module pwt_shot_seq
    import pwt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic [1:0] wr_run,
    input  logic      wr_oneshot,
    input  logic      oneshot,
    input  logic      cap_evt,
    input  logic      gate_open,
    output sq_state_e state,
    output logic      cap_allow,
    output logic      cnt_en,
    output logic      flag_set
);
    sq_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_ARMED: begin
                if (cap_evt)         st_d = SQ_ACTIVE;
                else if (!gate_open) st_d = SQ_WAITG;
            end
            SQ_WAITG: begin
                if (cap_evt || gate_open) st_d = SQ_ACTIVE;
            end
            SQ_ACTIVE: begin
                if (oneshot && cap_evt) st_d = SQ_DONE;
            end
            default: st_d = st_q;
        endcase
        if (ctrl_wr) begin
            if (wr_run == RUN_STOP)                     st_d = SQ_IDLE;
            else if (wr_oneshot && wr_run == RUN_SHOT)  st_d = SQ_ARMED;
            else                                        st_d = SQ_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    assign state     = st_q;
    assign cap_allow = (st_q == SQ_ARMED) || (st_q == SQ_WAITG) || (st_q == SQ_ACTIVE);
    assign cnt_en    = (st_q == SQ_ACTIVE) || (st_q == SQ_DONE) ||
                       ((st_q == SQ_WAITG) && gate_open);
    assign flag_set  = (st_q == SQ_ACTIVE) && cap_evt;

endmodule

// File: rtl/gated_pulse_timer.sv
module gated_pulse_timer
    import pwt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int ST_PAD = CNT_W - 5;

    typedef struct packed {
        logic [CNT_W-1:0] ctrl;
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             cap_flag;
        logic             ovf_flag;
    } regs_t;

    regs_t st_d, st_q;

    // control field views
    logic [1:0]       run_f;
    logic             oneshot_f, gate_en_f, gate_pol_f, reload_cap, irq_en_f;
    logic [1:0]       edge_f;
    logic [DIV_W-1:0] div_f;
    logic             run_on;

    assign run_f      = st_q.ctrl[1:0];
    assign oneshot_f  = st_q.ctrl[2];
    assign gate_en_f  = st_q.ctrl[3];
    assign gate_pol_f = st_q.ctrl[4];
    assign reload_cap = st_q.ctrl[5];
    assign irq_en_f   = st_q.ctrl[6];
    assign edge_f     = st_q.ctrl[8:7];
    assign div_f      = st_q.ctrl[9 +: DIV_W];
    assign run_on     = (run_f != RUN_STOP);

    // input conditioning
    logic pin_lvl, pin_rise, pin_fall;

    pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .level    (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    logic tick;

    pwt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_on),
        .div_code (div_f),
        .tick     (tick)
    );

    logic gate_open, edge_hit, cap_evt, ctrl_wr, cnt_wr;
    logic cap_allow, cnt_en, flag_set, inc, ovf_set;
    sq_state_e sq_state;
    logic [2:0] sq_bits;

    assign gate_open = !gate_en_f || (pin_lvl != gate_pol_f);
    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign cnt_wr    = wr_en && (wr_addr == A_COUNT);

    always_comb begin
        unique case (edge_f)
            EDGE_RISE: edge_hit = pin_rise;
            EDGE_FALL: edge_hit = pin_fall;
            EDGE_BOTH: edge_hit = pin_rise | pin_fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    assign cap_evt = run_on && cap_allow && edge_hit;

    pwt_shot_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_run     (wr_data[1:0]),
        .wr_oneshot (wr_data[2]),
        .oneshot    (oneshot_f),
        .cap_evt    (cap_evt),
        .gate_open  (gate_open),
        .state      (sq_state),
        .cap_allow  (cap_allow),
        .cnt_en     (cnt_en),
        .flag_set   (flag_set)
    );

    assign sq_bits = sq_state;
    assign inc     = run_on && cnt_en && tick && gate_open;

    always_comb begin
        st_d    = st_q;
        ovf_set = 1'b0;

        if (cap_evt) st_d.cap = st_q.cnt;

        if (cap_evt && reload_cap) begin
            st_d.cnt = st_q.rld;
        end else if (inc) begin
            if (st_q.cnt == '1) begin
                st_d.cnt = st_q.rld;
                ovf_set  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        if (flag_set) st_d.cap_flag = 1'b1;
        if (ovf_set)  st_d.ovf_flag = 1'b1;

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:   st_d.ctrl = wr_data;
                A_RELOAD: st_d.rld  = wr_data;
                A_COUNT:  st_d.cnt  = wr_data;
                A_STAT: begin
                    if (wr_data[0] && !flag_set) st_d.cap_flag = 1'b0;
                    if (wr_data[1] && !ovf_set)  st_d.ovf_flag = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // views for the bound checker and read mux
    logic [CNT_W-1:0] cnt_val, cap_val, rld_val;
    logic             cap_flag_w, ovf_flag_w;

    assign cnt_val    = st_q.cnt;
    assign cap_val    = st_q.cap;
    assign rld_val    = st_q.rld;
    assign cap_flag_w = st_q.cap_flag;
    assign ovf_flag_w = st_q.ovf_flag;

    always_comb begin
        unique case (rd_addr)
            A_CTRL:   rd_data = st_q.ctrl;
            A_RELOAD: rd_data = rld_val;
            A_COUNT:  rd_data = cnt_val;
            A_CAPT:   rd_data = cap_val;
            A_STAT:   rd_data = {{ST_PAD{1'b0}}, sq_bits, ovf_flag_w, cap_flag_w};
            default:  rd_data = '0;
        endcase
    end

    assign irq = cap_flag_w & irq_en_f;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic [CNT_W-1:0] rld,
    input logic             cap_evt,
    input logic             gate_open,
    input logic             cnt_wr,
    input logic             reload_cap,
    input logic [2:0]       state,
    input logic             cap_flag,
    input logic             ovf_flag
);
    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !cnt_wr && !cap_evt) |=> $stable(cnt));

    // R9
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4) |=> $stable(cap));

    // R10
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> ($past(state) == 3'd3));

    // R11
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == {CNT_W{1'b1}}));

    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && reload_cap && !cnt_wr) |=> (cnt == $past(rld)));

endmodule

bind gated_pulse_timer pwt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_val),
    .cap        (cap_val),
    .rld        (rld_val),
    .cap_evt    (cap_evt),
    .gate_open  (gate_open),
    .cnt_wr     (cnt_wr),
    .reload_cap (reload_cap),
    .state      (sq_bits),
    .cap_flag   (cap_flag_w),
    .ovf_flag   (ovf_flag_w)
);

// File: tb/sim_gated_pulse_timer.sv
module sim_gated_pulse_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    int    exp_q[$];
    string tag_q[$];

    // control words: run[1:0] shot[2] gate_en[3] pol[4] reload[5] irq_en[6] edge[8:7] div[11:9]
    localparam logic [15:0] C_CONT   = 16'h0169;
    localparam logic [15:0] C_NORLD  = 16'h0149;
    localparam logic [15:0] C_LOWRS  = 16'h00F9;
    localparam logic [15:0] C_SHOT   = 16'h016D;
    localparam logic [15:0] C_DIV4   = 16'h0401;
    localparam logic [15:0] C_FREE   = 16'h0001;
    localparam logic [15:0] C_NOIRQ  = 16'h0129;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_pulse_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic pulse(input logic lvl, input int width, input int gap);
        @(negedge clk);
        pin_in = lvl;
        repeat (width) @(negedge clk);
        pin_in = ~lvl;
        repeat (gap) @(negedge clk);
    endtask

    // driver: push expected capture then drive the pulse
    task automatic drive(input logic lvl, input int width, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        pulse(lvl, width, 8);
    endtask

    // monitor: wait for the interrupt, pop and compare, then clear the flag
    task automatic monitor();
        int v;
        int e;
        string t;
        int waited = 0;
        while (!irq && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " irq"}, int'(irq), 1);
        rd(3'd3, v);
        chk({t, " capture"}, v, e);
        wr(3'd4, 16'h0001);
        chk("R10 irq after clear", int'(irq), 0);
    endtask

    task automatic restart(input logic pin_lvl);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0003);
        pin_in = pin_lvl;
        repeat (5) @(negedge clk);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset reg", v, 0);
        end
        chk("R1 reset irq", int'(irq), 0);

        // R12 / R2 continuous, reload on capture
        restart(1'b0);
        wr(3'd0, C_CONT);
        drive(1'b1, 9, 9, "R2");
        repeat (4) @(negedge clk);
        chk("R10 flag sticky", int'(irq), 1);
        monitor();
        drive(1'b1, 3, 3, "R12");
        monitor();

        // R5 reload off accumulates
        restart(1'b0);
        wr(3'd0, C_NORLD);
        drive(1'b1, 5, 5, "R5");
        monitor();
        drive(1'b1, 7, 12, "R5");
        monitor();

        // R3 / R4 low pulse, rising edge, polarity 1
        restart(1'b1);
        wr(3'd0, C_LOWRS);
        drive(1'b0, 6, 6, "R3");
        monitor();

        // R7 single-shot armed with gate closed
        restart(1'b0);
        wr(3'd0, C_SHOT);
        repeat (3) @(negedge clk);
        rd(3'd4, v);
        chk("R7 wait state", (v >> 2) & 7, 2);
        drive(1'b1, 11, 11, "R7");
        monitor();
        rd(3'd4, v);
        chk("R9 done state", (v >> 2) & 7, 4);

        // R9 edges ignored after the cycle, counter still runs
        pulse(1'b1, 4, 8);
        rd(3'd3, v);
        chk("R9 capture held", v, 11);
        rd(3'd4, v);
        chk("R9 flag stays clear", v & 1, 0);
        rd(3'd2, v);
        chk("R9 counter ran", v, 4);

        // R9 re-arm, start on gate open keeps count
        wr(3'd0, C_SHOT);
        drive(1'b1, 5, 9, "R9 rearm");
        monitor();

        // R8 armed with gate open
        restart(1'b1);
        wr(3'd0, C_SHOT);
        repeat (3) @(negedge clk);
        rd(3'd4, v);
        chk("R8 armed state", (v >> 2) & 7, 1);
        rd(3'd2, v);
        chk("R8 no count while armed", v, 0);
        @(negedge clk);
        pin_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd4, v);
        chk("R8 start no flag", v & 1, 0);
        chk("R8 active state", (v >> 2) & 7, 3);
        drive(1'b1, 7, 7, "R8");
        monitor();

        // R6 prescaler divide by 4, gate off, no edge select
        restart(1'b0);
        wr(3'd0, C_DIV4);
        repeat (40) @(negedge clk);
        rd(3'd2, v);
        chk("R6 divided count", v, 10);
        pulse(1'b1, 5, 6);
        rd(3'd3, v);
        chk("R4 edge none capture", v, 7);
        rd(3'd4, v);
        chk("R4 edge none flag", v & 1, 0);

        // R11 overflow wraps to reload
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h1234);
        wr(3'd2, 16'hFFFE);
        wr(3'd4, 16'h0003);
        wr(3'd0, C_FREE);
        @(negedge clk);
        rd(3'd2, v);
        chk("R11 at max", v, 16'hFFFF);
        @(negedge clk);
        rd(3'd2, v);
        chk("R11 wrap", v, 16'h1234);
        rd(3'd4, v);
        chk("R11 ovf set", (v >> 1) & 1, 1);
        wr(3'd4, 16'h0002);
        rd(3'd4, v);
        chk("R11 ovf clear", (v >> 1) & 1, 0);

        // R13 stop holds count
        wr(3'd0, 16'h0000);
        rd(3'd2, v);
        begin
            int held;
            held = v;
            repeat (5) @(negedge clk);
            rd(3'd2, v);
            chk("R13 count held", v, held);
        end
        rd(3'd4, v);
        chk("R13 idle state", (v >> 2) & 7, 0);

        // R10 interrupt enable masks output, not flag
        restart(1'b0);
        wr(3'd0, C_NOIRQ);
        pulse(1'b1, 4, 8);
        rd(3'd4, v);
        chk("R10 flag set masked", v & 1, 1);
        chk("R10 irq masked", int'(irq), 0);
        rd(3'd3, v);
        chk("R10 capture", v, 4);
        wr(3'd0, C_CONT);
        chk("R10 irq unmasked", int'(irq), 1);

        chk("scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule